// File: doc/BRIEF.md
# Sequenced Reset Controller with Cause Capture

This block gathers reset requests and turns them into three active-low internal resets, all running on one slow clock. It produces a core-domain reset, a processor reset and a peripheral reset. It also drives an external reset line, which is modelled as open-drain: an output enable together with a driven value that is always low. Four general requests force a full reset of everything the block owns, its own registers included: power-on, the master reset pin, brownout and loss of supply regulation. The block then lets go of its resets in a fixed order. The core reset comes first. The processor and peripheral resets follow after a short startup delay. The external line is released after a pulse length chosen by software.

A fifth request, the auxiliary request, is a placeholder for sources such as a watchdog. It resets the processor, the peripherals and the external line, but it leaves the core domain and the mode register alone. The cause of the most recent reset is stored in a status field that software can read. That field changes only on the clock edge where the processor reset is released. A plain register port with address, write enable, write data and combinational read data gives access to the status field and to the pulse-length field.

Top module: `rstmgr_top`

## Requirements
- R1: While any of `por_i`, `bod_i` or `vreg_loss_i` is high, or `mrst_n_i` is low, all outputs take their reset values at once, without waiting for a clock edge: `core_rst_n_o`, `proc_rst_n_o` and `periph_rst_n_o` are 0, and the external line is driven low unless R6 applies.
- R2: `core_rst_n_o` rises on the second rising clock edge after the last general request is withdrawn. `proc_rst_n_o` and `periph_rst_n_o` are never high while `core_rst_n_o` is low.
- R3: `proc_rst_n_o` and `periph_rst_n_o` rise together, 2 clock edges after a reset sequence starts. A general sequence starts on the edge where `core_rst_n_o` rises. An auxiliary sequence starts on the last edge at which the synchronized request is still seen high.
- R4: `ext_oe_o` stays 1 until 2^(L+1) edges after the sequence start, where L is the pulse-length field as sampled at the sequence start. After a general reset L is 0, which gives 2 edges. The external line is never released before the processor reset.
- R5: The status register (address 0) holds the cause in bits [2:0]: 0 means general and 1 means auxiliary. It changes only on the edge where `proc_rst_n_o` rises.
- R6: While `off_mode_i` is 1, `ext_oe_o` is 0.
- R7: The mode register (address 1) holds the pulse-length field L in bits [3:0]. A write there takes effect on the next edge and reads back. A general reset clears it to 0. Unused bits and unmapped addresses read 0.
- R8: A write to address 0 leaves the status register unchanged.
- R9: `aux_req_i` passes through a two-stage synchronizer. While the synchronized request is high, it holds the processor reset, the peripheral reset and the external line asserted. `core_rst_n_o` and the mode register are not affected.
- R10: `ext_do_o` is always 0, so the external line is only ever pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | slow clock |
| por_i | input | 1 | power-on request, active high |
| mrst_n_i | input | 1 | master reset pin, active low |
| bod_i | input | 1 | brownout request, active high |
| vreg_loss_i | input | 1 | regulation-loss request, active high |
| aux_req_i | input | 1 | auxiliary reset request, active high |
| off_mode_i | input | 1 | OFF power mode, releases the external drive |
| reg_we_i | input | 1 | register write enable |
| reg_addr_i | input | 2 | register address |
| reg_wdata_i | input | 8 | register write data |
| reg_rdata_o | output | 8 | register read data (combinational) |
| core_rst_n_o | output | 1 | core-domain reset, active low |
| proc_rst_n_o | output | 1 | processor reset, active low |
| periph_rst_n_o | output | 1 | peripheral reset, active low |
| ext_oe_o | output | 1 | external reset line output enable |
| ext_do_o | output | 1 | external reset line value (constant 0) |

## Verification
Each result has a fixed arrival time, counted in edges. General requests act on the outputs at once. The core reset releases 2 edges after the last request is withdrawn, and the processor and peripheral resets release 2 edges after that. The external line follows 2^(L+1) edges after the sequence start. An auxiliary request is seen 2 edges after it is raised. The bench drives its inputs on falling edges. Its reference model steps once per rising edge and uses only the values of the inputs. Every output is compared 1 ns after each rising edge, so both the asynchronous effects and the synchronous ones are settled when they are sampled.

// File: rtl/rstmgr_pkg.sv
package rstmgr_pkg;
  typedef enum logic [2:0] {
    CAUSE_GENERAL = 3'd0,
    CAUSE_AUX     = 3'd1
  } cause_e;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_MODE   = 2'd1;
endpackage

// File: rtl/rstmgr_sync.sv
module rstmgr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstmgr_seq.sv
module rstmgr_seq
  import rstmgr_pkg::*;
#(
  parameter int ERSTL_W = 4,
  parameter int STARTUP = 2
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               hold_i,
  input  logic [ERSTL_W-1:0] erstl_i,
  output logic               proc_rst_n_o,
  output logic               ext_low_o,
  output logic               rel_o,
  output cause_e             cause_o
);
  localparam int CNT_W = (1 << ERSTL_W) + 1;

  logic [CNT_W-1:0]   cnt_q, cnt_nx, len_cyc;
  logic [ERSTL_W-1:0] len_q;
  logic               proc_q, ext_q;
  cause_e             pend_q;

  assign cnt_nx  = (&cnt_q) ? cnt_q : cnt_q + CNT_W'(1);
  assign len_cyc = CNT_W'(1) << (CNT_W'(len_q) + CNT_W'(1));
  assign rel_o   = !hold_i && !proc_q && (cnt_nx >= CNT_W'(STARTUP));

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cnt_q  <= '0;
      len_q  <= '0;
      proc_q <= 1'b0;
      ext_q  <= 1'b1;
      pend_q <= CAUSE_GENERAL;
    end else if (hold_i) begin
      cnt_q  <= '0;
      len_q  <= erstl_i;
      proc_q <= 1'b0;
      ext_q  <= 1'b1;
      pend_q <= CAUSE_AUX;
    end else begin
      cnt_q <= cnt_nx;
      if (rel_o) proc_q <= 1'b1;
      if (cnt_nx >= len_cyc) ext_q <= 1'b0;
    end
  end

  assign proc_rst_n_o = proc_q;
  assign ext_low_o    = ext_q;
  assign cause_o      = pend_q;

  p_ext_covers_proc_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !proc_q |-> ext_q)
    else $error("external line released before processor reset");

  p_hold_asserts_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    hold_i |=> (!proc_q && ext_q))
    else $error("auxiliary hold did not assert resets");
endmodule

// File: rtl/rstmgr_regs.sv
module rstmgr_regs
  import rstmgr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int ERSTL_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               upd_i,
  input  cause_e             cause_i,
  output logic [ERSTL_W-1:0] erstl_o,
  output cause_e             type_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [ERSTL_W-1:0] erstl_q;
  cause_e             type_q;
  logic               mode_wr;
  logic               unused_wdata;

  assign mode_wr      = we_i && (addr_i == ADDR_W'(ADDR_MODE));
  assign unused_wdata = ^wdata_i[DATA_W-1:ERSTL_W];

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      erstl_q <= '0;
      type_q  <= CAUSE_GENERAL;
    end else begin
      if (mode_wr) erstl_q <= wdata_i[ERSTL_W-1:0];
      if (upd_i)   type_q  <= cause_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_STATUS))    rdata_o = DATA_W'(type_q);
    else if (addr_i == ADDR_W'(ADDR_MODE)) rdata_o = DATA_W'(erstl_q);
  end

  assign erstl_o = erstl_q;
  assign type_o  = type_q;

  p_mode_write_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mode_wr |=> (erstl_q == $past(wdata_i[ERSTL_W-1:0])))
    else $error("mode write lost");

  p_status_ro_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (we_i && addr_i == ADDR_W'(ADDR_STATUS) && !upd_i) |=> $stable(type_q))
    else $error("status changed by write");
endmodule

// File: rtl/rstmgr_top.sv
module rstmgr_top
  import rstmgr_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int DATA_W  = 8,
  parameter int ERSTL_W = 4,
  parameter int STARTUP = 2,
  parameter int SYNC_N  = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              mrst_n_i,
  input  logic              bod_i,
  input  logic              vreg_loss_i,
  input  logic              aux_req_i,
  input  logic              off_mode_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              core_rst_n_o,
  output logic              proc_rst_n_o,
  output logic              periph_rst_n_o,
  output logic              ext_oe_o,
  output logic              ext_do_o
);
  logic               gen_req, core_n, aux_hold, proc_n, ext_low, rel;
  logic [ERSTL_W-1:0] erstl;
  cause_e             cause, rst_type;

  assign gen_req = por_i | ~mrst_n_i | bod_i | vreg_loss_i;

  rstmgr_sync #(.STAGES(SYNC_N)) u_core_sync (
    .clk_i(clk_i), .rst_n_i(~gen_req), .d_i(1'b1), .q_o(core_n));

  rstmgr_sync #(.STAGES(SYNC_N)) u_aux_sync (
    .clk_i(clk_i), .rst_n_i(core_n), .d_i(aux_req_i), .q_o(aux_hold));

  rstmgr_seq #(.ERSTL_W(ERSTL_W), .STARTUP(STARTUP)) u_seq (
    .clk_i(clk_i), .rst_n_i(core_n), .hold_i(aux_hold), .erstl_i(erstl),
    .proc_rst_n_o(proc_n), .ext_low_o(ext_low), .rel_o(rel), .cause_o(cause));

  rstmgr_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERSTL_W(ERSTL_W)) u_regs (
    .clk_i(clk_i), .rst_n_i(core_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .upd_i(rel), .cause_i(cause), .erstl_o(erstl),
    .type_o(rst_type), .rdata_o(reg_rdata_o));

  assign core_rst_n_o   = core_n;
  assign proc_rst_n_o   = proc_n;
  assign periph_rst_n_o = proc_n;
  assign ext_oe_o       = ext_low & ~off_mode_i;
  assign ext_do_o       = 1'b0;

  p_core_gates_r2: assert property (@(posedge clk_i) disable iff (por_i)
    !core_n |-> (!proc_rst_n_o && !periph_rst_n_o))
    else $error("processor reset released under core reset");

  p_cause_on_release_r5: assert property (@(posedge clk_i) disable iff (!core_n)
    !$stable(rst_type) |-> $rose(proc_rst_n_o))
    else $error("cause changed outside processor release");
endmodule

// File: tb/rstmgr_top_tb_top.sv
`timescale 1ns/1ps
module rstmgr_top_tb_top;
  logic clk = 1'b0;
  logic por = 1'b1, mrst_n = 1'b1, bod = 1'b0, vreg = 1'b0, aux = 1'b0, off = 1'b0;
  logic we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic core_n, proc_n, peri_n, ext_oe, ext_do;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rstmgr_top dut_i (
    .clk_i(clk), .por_i(por), .mrst_n_i(mrst_n), .bod_i(bod), .vreg_loss_i(vreg),
    .aux_req_i(aux), .off_mode_i(off), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .core_rst_n_o(core_n),
    .proc_rst_n_o(proc_n), .periph_rst_n_o(peri_n), .ext_oe_o(ext_oe), .ext_do_o(ext_do));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int s1 = 0, s2 = 0, a1 = 0, a2 = 0, cnt = 0, prc = 0, extl = 1;
  int lenq = 0, pend = 0, rtype = 0, erstl = 0;
  localparam int CMAX = (1 << 17) - 1;

  always @(posedge clk) begin
    int hold, nc, ne;
    if (por || !mrst_n || bod || vreg) begin
      s1 = 0; s2 = 0; a1 = 0; a2 = 0; cnt = 0; prc = 0; extl = 1;
      lenq = 0; pend = 0; rtype = 0; erstl = 0;
    end else if (s2 == 0) begin
      s2 = s1; s1 = 1;
    end else begin
      hold = a2; a2 = a1; a1 = aux;
      ne = (we && addr == 2'd1) ? int'(wdata[3:0]) : erstl;
      if (hold != 0) begin
        cnt = 0; prc = 0; extl = 1; lenq = erstl; pend = 1;
      end else begin
        nc = (cnt == CMAX) ? cnt : cnt + 1;
        if (prc == 0 && nc >= 2) begin prc = 1; rtype = pend; end
        if (nc >= (1 << (lenq + 1))) extl = 0;
        cnt = nc;
      end
      erstl = ne;
    end
    #1;
    if (!done) begin
      chk("R2 core reset", int'(core_n), s2);
      chk("R3 processor reset", int'(proc_n), prc);
      chk("R3 peripheral reset", int'(peri_n), prc);
      chk("R4/R6 external enable", int'(ext_oe), (extl != 0 && !off) ? 1 : 0);
      chk("R10 external value", int'(ext_do), 0);
      chk("R5/R7 read data", int'(rdata),
          (addr == 2'd0) ? rtype : (addr == 2'd1) ? erstl : 0);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = 8'd0;
  endtask

  task automatic aux_pulse(int n);
    @(negedge clk); aux = 1'b1;
    cyc(n);
    aux = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(4);
    // R1: reset state while power-on request held
    chk("R1 core low in reset", int'(core_n), 0);
    chk("R1 ext driven in reset", int'(ext_oe), 1);
    @(negedge clk); por = 1'b0;
    cyc(8);
    // R5: general cause after release
    addr = 2'd0; cyc(1);
    chk("R5 cause general", int'(rdata), 0);
    // R8: status write ignored
    wr(2'd0, 8'hFF); cyc(1);
    chk("R8 status unchanged", int'(rdata), 0);
    // R7: mode write and readback, unmapped address reads 0
    wr(2'd1, 8'hF3); addr = 2'd1; cyc(1);
    chk("R7 mode readback", int'(rdata), 3);
    addr = 2'd3; cyc(1);
    chk("R7 unmapped reads 0", int'(rdata), 0);
    // R9: auxiliary request with L=3, core untouched
    addr = 2'd0;
    aux_pulse(3);
    cyc(1);
    chk("R9 core untouched", int'(core_n), 1);
    cyc(24);
    chk("R5 cause auxiliary", int'(rdata), 1);
    // R6: off mode during an auxiliary reset with L=2
    wr(2'd1, 8'h02);
    @(negedge clk); off = 1'b1;
    aux_pulse(2);
    cyc(3);
    chk("R6 off mode no drive", int'(ext_oe), 0);
    cyc(12);
    @(negedge clk); off = 1'b0;
    // R1: brownout asserts resets without a clock edge, clears mode (R7)
    @(negedge clk); bod = 1'b1; #1;
    chk("R1 async core reset", int'(core_n), 0);
    chk("R1 async processor reset", int'(proc_n), 0);
    @(negedge clk); bod = 1'b0;
    cyc(8);
    addr = 2'd1; cyc(1);
    chk("R7 mode cleared by general reset", int'(rdata), 0);
    // other general sources
    @(negedge clk); mrst_n = 1'b0; cyc(3); mrst_n = 1'b1; cyc(8);
    @(negedge clk); vreg = 1'b1; cyc(1); vreg = 1'b0; cyc(8);
    // R4: longest pulse, L=15 gives 65536 edges
    wr(2'd1, 8'h0F);
    addr = 2'd0;
    aux_pulse(2);
    cyc(65560);
    chk("R4 long pulse ended", int'(ext_oe), 0);
    cyc(4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule